// File: doc/BRIEF.md
# Five-Pin GPIO with Register-Bit Monitoring

The block is a small general-purpose I/O controller for five pins behind a simple register bus. The bus does single-cycle writes and reads with combinational read data. Each pin works either as a plain input or output, or as a monitor that mirrors one chosen bit of a 32-bit register. That register sits in a separate 16-bit indirect register space.

Monitor mode is all-or-nothing. Monitoring starts only when every pin's monitor-enable bit is set. When that happens, a polling port visits the pins in turn. For each pin it presents the word address from that pin's entry, waits for a one-cycle response, and latches the selected bit onto the pin.

If the monitor-enable field mixes set and clear bits, the block raises a configuration-error flag. It then keeps every pin in plain I/O use until software writes a legal field.

Top module: `gpio_bitmon`

## Requirements
- R1: After reset every register field, `pin_out`, `pin_oe`, `poll_req` and `cfg_err` are zero, so all pins are inputs and no polling takes place.
- R2: A write to the control word (offset 0x0) sets the direction bits in [4:0], the level bits in [12:8] and the monitor-enable bits in [20:16]. From the next cycle `pin_oe` equals the direction field. In plain I/O use, `pin_out` equals the written level field.
- R3: For a pin whose direction bit is 0, the level bit read back from the control word is `pin_in` delayed by a two-flop synchronizer. A change on `pin_in` before clock edge k is therefore readable after edge k+1.
- R4: A read of the control word returns direction in [4:0], the effective level in [12:8], monitor enable in [20:16] and the error flag in bit 31. All other bits read as zero.
- R5: The monitor entry for pin i sits at offset 0x1+i. It holds a 16-bit indirect address in [15:0] and a 5-bit bit index in [28:24]. All other bits are dropped on write and read as zero.
- R6: Offset 0xF is read-only and returns 0x0000F901 (version 0x01 in [7:0], identifier 0xF9 in [15:8]). Writes to it change nothing.
- R7: When a control write leaves the monitor-enable field neither all zeros nor all ones, `cfg_err` is 1 from the next cycle. While it is 1, `poll_req` stays 0 and the pins act as plain I/O.
- R8: `cfg_err` stays set until a control write makes the monitor-enable field all zeros or all ones. It is 0 from the cycle after that write.
- R9: With all monitor-enable bits set, `poll_req` is 1 and `poll_addr` carries the entry address of the current pin, starting from pin 0 and going round-robin 0..4. A cycle with `poll_rvalid` high stores bit `poll_rdata[index]` of that response for the current pin, visible on `pin_out` one cycle later, and advances to the next pin. Index 0 selects bit 0 and index 31 selects bit 31.
- R10: A `poll_rvalid` pulse while `poll_req` is 0 has no effect on `pin_out` or on any read value.
- R11: In monitor mode the level field of the control read returns the monitored value of each pin. Leaving monitor mode clears the monitored values and restarts polling at pin 0 on the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| poll_req | output | 1 | Monitor polling active |
| poll_addr | output | 16 | Indirect word address of the pin being polled |
| poll_rvalid | input | 1 | One-cycle response strobe |
| poll_rdata | input | 32 | Response word |
| pin_in | input | 5 | Pad input values |
| pin_out | output | 5 | Pad output values |
| pin_oe | output | 5 | Pad output enables |
| cfg_err | output | 1 | Illegal monitor-enable mix flag |

## Verification
The bench builds the block with its default values: five pins, a 16-bit indirect address, a 32-bit data word and the version constants 0x01 and 0xF9. These values make the round-robin wrap from pin 4 back to pin 0 observable, and they let the bit indices reach both ends, 0 and 31. They also let a field mixing set and clear monitor bits be written and cleared again.

The responder skips every third cycle. Its valid pulses keep arriving while the block is not polling, which covers the stray-response case.

// File: rtl/gpio_bitmon.sv
module gpio_bitmon #(
  parameter int          NPIN    = 5,
  parameter int          IADDR_W = 16,
  parameter int          DATA_W  = 32,
  parameter int          RADDR_W = 4,
  parameter logic [7:0]  VER_NUM = 8'h01,
  parameter logic [7:0]  VER_ID  = 8'hF9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RADDR_W-1:0] bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               poll_req,
  output logic [IADDR_W-1:0] poll_addr,
  input  logic               poll_rvalid,
  input  logic [DATA_W-1:0]  poll_rdata,
  input  logic [NPIN-1:0]    pin_in,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe,
  output logic               cfg_err
);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam int PTR_W  = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int DIR_LO = 0;
  localparam int LVL_LO = 8;
  localparam int MON_LO = 16;
  localparam int ERR_B  = 31;
  localparam int BIT_LO = 24;
  localparam logic [RADDR_W-1:0] A_CTRL = '0;
  localparam logic [RADDR_W-1:0] A_VER  = '1;

  logic [NPIN-1:0]    dir_q, lvl_q, mon_q, sync1_q, sync2_q, mval_q;
  logic [IADDR_W-1:0] ent_addr [NPIN];
  logic [BIDX_W-1:0]  ent_bit  [NPIN];
  logic [PTR_W-1:0]   ptr_q;
  logic               err_q;

  wire mon_mode = &mon_q;
  wire ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  wire [NPIN-1:0] wmon = bus_wdata[MON_LO +: NPIN];
  wire [NPIN-1:0] lvl_eff = mon_mode ? mval_q : ((dir_q & lvl_q) | (~dir_q & sync2_q));

  assign pin_oe    = dir_q;
  assign pin_out   = mon_mode ? mval_q : lvl_q;
  assign poll_req  = mon_mode;
  assign poll_addr = ent_addr[ptr_q];
  assign cfg_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      mon_q <= '0;
      err_q <= 1'b0;
    end else if (ctrl_wr) begin
      dir_q <= bus_wdata[DIR_LO +: NPIN];
      lvl_q <= bus_wdata[LVL_LO +: NPIN];
      mon_q <= wmon;
      err_q <= (wmon != '0) && (wmon != '1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_ent
    wire sel = bus_wr && (bus_addr == RADDR_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[g] <= '0;
        ent_bit[g]  <= '0;
      end else if (sel) begin
        ent_addr[g] <= bus_wdata[IADDR_W-1:0];
        ent_bit[g]  <= bus_wdata[BIT_LO +: BIDX_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mval_q <= '0;
    end else if (!mon_mode) begin
      ptr_q  <= '0;
      mval_q <= '0;
    end else if (poll_rvalid) begin
      mval_q[ptr_q] <= poll_rdata[ent_bit[ptr_q]];
      ptr_q <= (ptr_q == PTR_W'(NPIN - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[DIR_LO +: NPIN] = dir_q;
      bus_rdata[LVL_LO +: NPIN] = lvl_eff;
      bus_rdata[MON_LO +: NPIN] = mon_q;
      bus_rdata[ERR_B]          = err_q;
    end else if (bus_addr == A_VER) begin
      bus_rdata[15:0] = {VER_ID, VER_NUM};
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (bus_addr == RADDR_W'(i + 1)) begin
          bus_rdata[IADDR_W-1:0]      = ent_addr[i];
          bus_rdata[BIT_LO +: BIDX_W] = ent_bit[i];
        end
      end
    end
  end
endmodule

// File: rtl/gpio_bitmon_chk.sv
module gpio_bitmon_chk #(
  parameter int          NPIN    = 5,
  parameter int          IADDR_W = 16,
  parameter int          RADDR_W = 4,
  parameter logic [7:0]  VER_NUM = 8'h01,
  parameter logic [7:0]  VER_ID  = 8'hF9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RADDR_W-1:0] bus_addr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               poll_req,
  input logic [IADDR_W-1:0] poll_addr,
  input logic               poll_rvalid,
  input logic [NPIN-1:0]    pin_oe,
  input logic               cfg_err
);
  wire            ctrl_wr = bus_wr && (bus_addr == '0);
  wire [NPIN-1:0] wm      = bus_wdata[16 +: NPIN];
  wire            w_mixed = (wm != '0) && (wm != '1);

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> pin_oe == $past(bus_wdata[NPIN-1:0]));

  p_version_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '1) |-> bus_rdata == {16'h0, VER_ID, VER_NUM});

  p_mixed_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w_mixed) |=> cfg_err);

  p_no_poll_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !poll_req);

  p_legal_clears_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !w_mixed) |=> !cfg_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !ctrl_wr) |=> cfg_err);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_rvalid && !bus_wr) |=> $stable(poll_addr));
endmodule

bind gpio_bitmon gpio_bitmon_chk #(
  .NPIN(NPIN), .IADDR_W(IADDR_W), .RADDR_W(RADDR_W),
  .VER_NUM(VER_NUM), .VER_ID(VER_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .poll_req(poll_req),
  .poll_addr(poll_addr), .poll_rvalid(poll_rvalid), .pin_oe(pin_oe),
  .cfg_err(cfg_err)
);

// File: tb/test_gpio_bitmon.sv
module test_gpio_bitmon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        poll_req;
  logic [15:0] poll_addr;
  logic        poll_rvalid = 1'b0;
  logic [31:0] poll_rdata = '0;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_out, pin_oe;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  bit resp_on = 0;
  bit live = 0;
  int cyc = 0;

  gpio_bitmon i_gpio_bitmon (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .poll_req(poll_req),
    .poll_addr(poll_addr), .poll_rvalid(poll_rvalid), .poll_rdata(poll_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [4:0]  m_dir = 0, m_lvl = 0, m_mon = 0, m_s1 = 0, m_s2 = 0, m_mv = 0;
  logic [15:0] m_addr [5];
  logic [4:0]  m_bit  [5];
  int          m_ptr = 0;
  logic        m_err = 0;

  function automatic logic [31:0] mem(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a, a[15:8] ^ 8'h3E};
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] r = '0;
    logic [4:0]  lv;
    if (a == 4'h0) begin
      lv = (&m_mon) ? m_mv : ((m_dir & m_lvl) | (~m_dir & m_s2));
      r = {m_err, 10'b0, m_mon, 3'b0, lv, 3'b0, m_dir};
    end else if (a == 4'hF) r = 32'h0000F901;
    else if (a >= 4'h1 && a <= 4'h5) r = {3'b0, m_bit[a-1], 8'h0, m_addr[a-1]};
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_lvl = 0; m_mon = 0; m_s1 = 0; m_s2 = 0; m_mv = 0;
      m_ptr = 0; m_err = 0;
      for (int i = 0; i < 5; i++) begin m_addr[i] = 0; m_bit[i] = 0; end
    end else begin
      m_s2 = m_s1; m_s1 = pin_in;
      if (!(&m_mon)) begin m_ptr = 0; m_mv = 0; end
      else if (poll_rvalid) begin
        m_mv[m_ptr] = poll_rdata[m_bit[m_ptr]];
        m_ptr = (m_ptr + 1) % 5;
      end
      if (bus_wr) begin
        if (bus_addr == 4'h0) begin
          m_dir = bus_wdata[4:0]; m_lvl = bus_wdata[12:8]; m_mon = bus_wdata[20:16];
          m_err = (m_mon != 5'b0) && (m_mon != 5'b11111);
        end else if (bus_addr >= 4'h1 && bus_addr <= 4'h5) begin
          m_addr[bus_addr-1] = bus_wdata[15:0];
          m_bit[bus_addr-1]  = bus_wdata[28:24];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of all outputs against the model
  always @(negedge clk) if (live) begin
    chk("R2 pin_oe", {27'b0, pin_oe}, {27'b0, m_dir});
    chk((&m_mon) ? "R9 pin_out" : "R2 pin_out", {27'b0, pin_out}, {27'b0, (&m_mon) ? m_mv : m_lvl});
    chk((&m_mon) ? "R9 poll_req" : "R7 poll_req", {31'b0, poll_req}, {31'b0, &m_mon});
    if (&m_mon) chk("R9 poll_addr", {16'b0, poll_addr}, {16'b0, m_addr[m_ptr]});
    chk("R7 cfg_err", {31'b0, cfg_err}, {31'b0, m_err});
  end

  // responder: answers two cycles out of three, even when nothing is requested (R10)
  initial forever begin
    @(negedge clk); #2;
    if (resp_on) begin
      cyc++;
      poll_rvalid = (cyc % 3) != 1;
      poll_rdata  = mem(poll_addr);
    end else poll_rvalid = 0;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); #2;
    bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    @(negedge clk); #2;
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); live = 1;
    // R1 reset state
    chk("R1 outputs", {pin_out, pin_oe, poll_req, cfg_err}, 0);
    for (int a = 0; a < 6; a++) rd("R1 reg", 4'(a));

    // R2 / R4 control layout with reserved bits set in the write data
    wr(4'h0, 32'h7F00_F6E0 | 32'h0000_1A16);
    rd("R4 ctrl", 4'h0);
    wr(4'h0, 32'h0000_0B1F);
    rd("R4 ctrl all out", 4'h0);

    // R3 inputs through the synchronizer
    wr(4'h0, 32'h0000_1503);
    pin_in = 5'b10110;
    rd("R3 lvl early", 4'h0);
    rd("R3 lvl", 4'h0);
    rd("R3 lvl settled", 4'h0);
    pin_in = 5'b01101;
    idle(3);
    rd("R3 lvl new", 4'h0);

    // R5 monitor entries, bit index at both ends
    wr(4'h1, {3'b111, 5'd0,  8'hFF, 16'h1234});
    wr(4'h2, {3'b111, 5'd31, 8'hFF, 16'hBEEF});
    wr(4'h3, {3'b000, 5'd17, 8'h00, 16'h0F0F});
    wr(4'h4, {3'b101, 5'd5,  8'hAA, 16'hFFFF});
    wr(4'h5, {3'b010, 5'd31, 8'h55, 16'h0000});
    for (int a = 1; a < 6; a++) rd("R5 entry", 4'(a));

    // R6 version read-only
    rd("R6 version", 4'hF);
    wr(4'hF, 32'hFFFF_FFFF);
    rd("R6 version after write", 4'hF);
    rd("R6 ctrl unchanged", 4'h0);

    // R7 mixed field, with stray responses (R10)
    resp_on = 1;
    wr(4'h0, 32'h0005_1F1F);
    idle(8);
    rd("R7 err flag", 4'h0);
    chk("R10 pin_out plain", {27'b0, pin_out}, {27'b0, m_lvl});
    // R8 clear by legal write, set again, clear by all-ones
    wr(4'h0, 32'h0000_0A1F);
    rd("R8 cleared", 4'h0);
    wr(4'h0, 32'h001E_001F);
    rd("R8 set again", 4'h0);

    // R9 / R11 monitor mode
    wr(4'h0, 32'h001F_001F);
    for (int k = 0; k < 12; k++) begin idle(3); rd("R11 mon level", 4'h0); end
    // retarget an entry mid-run
    wr(4'h3, {3'b0, 5'd3, 8'h0, 16'h00F0});
    idle(20);
    rd("R11 mon level retarget", 4'h0);
    // leave and re-enter monitor mode
    wr(4'h0, 32'h0000_1F1F);
    idle(4);
    rd("R11 left mon", 4'h0);
    resp_on = 0;
    wr(4'h0, 32'h001F_001F);
    idle(3);
    chk("R11 restart at pin 0", {16'b0, poll_addr}, {16'b0, 16'h1234});
    resp_on = 1;
    idle(30);
    rd("R11 mon level again", 4'h0);
    resp_on = 0;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule